// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit sits between a processor-side register port and a serial shifter. It holds two 32-byte queues. The transmit queue is loaded by bus writes and drained one byte at a time by the shifter. The receive queue is filled one byte at a time by the shifter and read back over the bus. A bus access to either data port may be 8, 16 or 32 bits wide and moves 1, 2 or 4 bytes in big-endian order: the first byte in the queue sits in the most significant lane of the accessed field.

A status word combines live queue occupancy (receive bytes held, transmit bytes free) with sticky event flags. Software clears a flag by writing a one to its position. A mask word uses the same bit positions, and the interrupt request is the OR of all flags that are both set and unmasked. A mode word carries the enable, the loopback request and the two threshold fields.

A small controller tracks the unit's activity in three states. OFF is held while the enable bit is clear, and both queues are flushed there. IDLE is the enabled state with nothing queued for transmission. RUN means the transmit queue has data and a transaction is in progress. The transitions are:
- enable-on, OFF to IDLE.
- disable, from IDLE or RUN to OFF.
- start, IDLE to RUN when the transmit queue is not empty.
- finish, RUN to IDLE on a transaction-done pulse.

Top module: `spif_event_unit`

## Requirements
- R1: Each queue holds exactly 32 bytes; a queue never reports more than 32 bytes held.
- R2: The status word (byte offset 0x04) reports the receive byte count in bits 29:24 and the transmit free space in bits 21:16. The free space is 32 when the transmit queue is empty, and all other non-flag bits read 0.
- R3: Status flags are set while the unit is enabled, whenever their condition holds: bit 15 transmit queue empty, bit 14 done pulse seen, bit 13 receive threshold, bit 12 receive queue full, bit 11 transmit threshold, bit 9 receive queue not empty, bit 8 transmit queue not full. Bit 10 reads 0.
- R4: Writing a one to a flag position of the status word clears that flag. A condition that still holds in the same cycle keeps the flag set.
- R5: The mask word (byte offset 0x08) holds bits 15:8 at the flag positions and reads back what was written. The interrupt request is high exactly when some flag and its mask bit are both set.
- R6: A write to the transmit port (byte offset 0x0C) with size code 0, 1 or 2 queues 1, 2 or 4 bytes. For code 0 the byte is taken from bits 7:0, for code 1 from bits 15:8 then 7:0, and for code 2 from bits 31:24 first down to 7:0.
- R7: A read of the receive port (byte offset 0x10) with size code 0, 1 or 2 removes up to 1, 2 or 4 bytes. The oldest byte is placed in the most significant byte of the accessed field, and missing bytes read as 0.
- R8: The mode word (byte offset 0x00) holds the enable in bit 31, loopback in bit 30, the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. It resets to 0x0000040F, which means disabled, transmit threshold 4 and receive threshold 15.
- R9: The receive threshold flag requires the receive count to be strictly above the receive threshold. The transmit threshold flag requires the transmit free space to be strictly above the transmit threshold.
- R10: While the enable bit is clear, both queues are empty, shifter pushes and bus pushes are ignored, no flag is set and the controller stays in OFF.
- R11: A transmit write that does not fit in the free space is dropped whole, and a receive push into a full queue is dropped. A shifter pop of an empty transmit queue yields byte 0.
- R12: busy_o is high only in RUN. The controller takes start from IDLE when transmit data is queued, stays in RUN until a done pulse, then takes finish back to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the accessed word |
| bus_size_i | input | 2 | Access size code: 0 = 8, 1 = 16, 2 = 32 bits |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| tx_pop_i | input | 1 | Shifter takes one transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte, 0 when empty |
| tx_avail_o | output | 1 | Transmit queue not empty |
| rx_push_i | input | 1 | Shifter delivers one receive byte |
| rx_byte_i | input | 8 | Received byte |
| done_i | input | 1 | Transaction-done pulse |
| enable_o | output | 1 | Mode enable bit |
| loop_o | output | 1 | Mode loopback bit |
| busy_o | output | 1 | Controller in RUN |
| irq_o | output | 1 | Interrupt request |

## Verification
The queues are driven with a seeded random mix of 8-, 16- and 32-bit transmit writes, single-byte shifter pops, shifter pushes and receive reads of random width. This shows whether byte order and lane placement are right for every width, including reads that run past the data held. Directed cases then fill each queue to exactly 32 bytes and push once more, read an empty queue, and put counts on either side of each threshold, which separates a strict comparison from a non-strict one. A status read after clearing all flags, made at each checkpoint, tells apart flags that are held from flags that are only level conditions. Disabling with data queued shows both the flush and the suppression of flags.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned LANES = BUS_W / 8;

    localparam logic [4:0] ADR_MODE = 5'h00;
    localparam logic [4:0] ADR_EVT  = 5'h04;
    localparam logic [4:0] ADR_MASK = 5'h08;
    localparam logic [4:0] ADR_TXD  = 5'h0C;
    localparam logic [4:0] ADR_RXD  = 5'h10;

    // flag positions within the upper byte of the low half-word (bit - 8)
    localparam int FL_TXE  = 7;
    localparam int FL_DONE = 6;
    localparam int FL_RXT  = 5;
    localparam int FL_RXF  = 4;
    localparam int FL_TXT  = 3;
    localparam int FL_RNE  = 1;
    localparam int FL_TNF  = 0;
    localparam logic [7:0] FLAG_USED = 8'b1111_1011;

    localparam logic [5:0] TXTHR_RST = 6'd4;
    localparam logic [5:0] RXTHR_RST = 6'd15;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic       en;
        logic       lp;
        logic [5:0] txthr;
        logic [5:0] rxthr;
    } mode_t;

    function automatic int size_bytes(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/spif_byte_fifo.sv
module spif_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LANES = 4,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = PW + 1,
    localparam int unsigned NW = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [NW-1:0]      push_n_i,
    input  logic [LANES*8-1:0] push_data_i,
    input  logic [NW-1:0]      pop_n_i,
    output logic [LANES*8-1:0] peek_o,
    output logic [CW-1:0]      count_o
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] free;
    logic [NW-1:0] push_acc, pop_acc;

    always_comb begin
        free     = CW'(DEPTH) - cnt_q;
        push_acc = (CW'(push_n_i) <= free) ? push_n_i : '0;
        pop_acc  = (CW'(pop_n_i) <= cnt_q) ? pop_n_i : NW'(cnt_q);
    end

    always_ff @(posedge clk) begin
        if (!flush_i) begin
            for (int k = 0; k < int'(LANES); k++) begin
                if (NW'(k) < push_acc) begin
                    mem[wr_q + PW'(k)] <= push_data_i[8*k +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_q + PW'(push_acc);
            rd_q  <= rd_q + PW'(pop_acc);
            cnt_q <= cnt_q + CW'(push_acc) - CW'(pop_acc);
        end
    end

    always_comb begin
        for (int k = 0; k < int'(LANES); k++) begin
            peek_o[8*k +: 8] = (CW'(k) < cnt_q) ? mem[rd_q + PW'(k)] : 8'h00;
        end
    end

    assign count_o = cnt_q;

    // R1: occupancy never exceeds capacity
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R11: a push into a full queue changes nothing
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DEPTH) && pop_n_i == '0 && push_n_i != '0 && !flush_i)
        |=> cnt_q == CW'(DEPTH));

    // R11: a pop from an empty queue leaves it empty
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && push_n_i == '0 && pop_n_i != '0 && !flush_i)
        |=> cnt_q == '0);

    // R10: flush empties the queue
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> cnt_q == '0);

endmodule

// File: rtl/spif_ctl_fsm.sv
module spif_ctl_fsm
    import spif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       tx_pending_i,
    input  logic       done_i,
    output ctl_state_t state_o,
    output logic       busy_o
);

    ctl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable_i) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!enable_i)         state_d = ST_OFF;
                else if (tx_pending_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable_i)   state_d = ST_OFF;
                else if (done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        state_o = state_q;
        busy_o  = (state_q == ST_RUN);
    end

    // R10: a cleared enable forces OFF on the next cycle
    p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_q == ST_OFF);

    // R12: RUN is held until a done pulse or disable
    p_run_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && enable_i && !done_i) |=> busy_o);

endmodule

// File: rtl/spif_regs.sv
module spif_regs
    import spif_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mode_i,
    input  logic          wr_evt_i,
    input  logic          wr_mask_i,
    input  logic [31:0]   wdata_i,
    input  logic          done_i,
    input  logic [CW-1:0] rx_cnt_i,
    input  logic [CW-1:0] tx_cnt_i,
    output mode_t         mode_o,
    output logic [31:0]   mode_word_o,
    output logic [31:0]   evt_o,
    output logic [31:0]   mask_o,
    output logic          irq_o
);

    mode_t         mode_q;
    logic [7:0]    flg_q, mask_q;
    logic [7:0]    cond, clr;
    logic [CW-1:0] tx_free;
    logic          unused_wdata;

    assign unused_wdata = ^{wdata_i[29:16], wdata_i[7:6]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{en: 1'b0, lp: 1'b0, txthr: TXTHR_RST, rxthr: RXTHR_RST};
        end else if (wr_mode_i) begin
            mode_q <= '{en: wdata_i[31], lp: wdata_i[30],
                        txthr: wdata_i[13:8], rxthr: wdata_i[5:0]};
        end
    end

    always_comb begin
        tx_free          = CW'(DEPTH) - tx_cnt_i;
        cond             = '0;
        cond[FL_TXE]     = (tx_cnt_i == '0);
        cond[FL_DONE]    = done_i;
        cond[FL_RXT]     = int'(rx_cnt_i) > int'(mode_q.rxthr);
        cond[FL_RXF]     = (rx_cnt_i == CW'(DEPTH));
        cond[FL_TXT]     = int'(tx_free) > int'(mode_q.txthr);
        cond[FL_RNE]     = (rx_cnt_i != '0);
        cond[FL_TNF]     = (tx_free != '0);
        clr              = wr_evt_i ? (wdata_i[15:8] & FLAG_USED) : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q  <= '0;
            mask_q <= '0;
        end else begin
            flg_q <= (flg_q & ~clr) | (mode_q.en ? cond : 8'h00);
            if (wr_mask_i) mask_q <= wdata_i[15:8] & FLAG_USED;
        end
    end

    always_comb begin
        mode_o       = mode_q;
        mode_word_o  = {mode_q.en, mode_q.lp, 16'h0000, mode_q.txthr, 2'b00, mode_q.rxthr};
        evt_o        = '0;
        evt_o[24 +: CW] = rx_cnt_i;
        evt_o[16 +: CW] = tx_free;
        evt_o[15:8]  = flg_q;
        mask_o       = {16'h0000, mask_q, 8'h00};
        irq_o        = |(flg_q & mask_q);
    end

    // R3: an enabled done pulse is recorded
    p_done_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.en && done_i) |=> flg_q[FL_DONE]);

    // R4: write-one clears the done flag when no new pulse arrives
    p_w1c_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt_i && wdata_i[8 + FL_DONE] && !done_i) |=> !flg_q[FL_DONE]);

    // R10: no flag appears while disabled
    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.en && !wr_mode_i && flg_q == '0) |=> flg_q == '0);

endmodule

// File: rtl/spif_event_unit.sv
module spif_event_unit
    import spif_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic [4:0]  bus_addr_i,
    input  logic [1:0]  bus_size_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        tx_pop_i,
    output logic [7:0]  tx_byte_o,
    output logic        tx_avail_o,
    input  logic        rx_push_i,
    input  logic [7:0]  rx_byte_i,
    input  logic        done_i,
    output logic        enable_o,
    output logic        loop_o,
    output logic        busy_o,
    output logic        irq_o
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam int unsigned NW = $clog2(LANES + 1);

    int                 nb;
    logic               wr_any, rd_any;
    logic [NW-1:0]      tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
    logic [LANES*8-1:0] tx_lanes, tx_peek, rx_peek, rx_lanes;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    mode_t              mode;
    logic [31:0]        mode_word, evt_word, mask_word;
    ctl_state_t         state;
    logic               unused_tx_peek;

    assign unused_tx_peek = ^tx_peek[LANES*8-1:8];

    always_comb begin
        nb       = size_bytes(bus_size_i);
        wr_any   = bus_sel_i && bus_wr_i;
        rd_any   = bus_sel_i && !bus_wr_i;
        tx_push_n = (wr_any && bus_addr_i == ADR_TXD) ? NW'(nb) : '0;
        rx_pop_n  = (rd_any && bus_addr_i == ADR_RXD) ? NW'(nb) : '0;
        tx_pop_n  = tx_pop_i ? NW'(1) : '0;
        rx_push_n = (rx_push_i && mode.en) ? NW'(1) : '0;
        rx_lanes  = {{(LANES*8-8){1'b0}}, rx_byte_i};
        tx_lanes  = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            if (k < nb) tx_lanes[8*k +: 8] = bus_wdata_i[8*(nb-1-k) +: 8];
        end
    end

    spif_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (!mode.en),
        .push_n_i    (tx_push_n),
        .push_data_i (tx_lanes),
        .pop_n_i     (tx_pop_n),
        .peek_o      (tx_peek),
        .count_o     (tx_cnt)
    );

    spif_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (!mode.en),
        .push_n_i    (rx_push_n),
        .push_data_i (rx_lanes),
        .pop_n_i     (rx_pop_n),
        .peek_o      (rx_peek),
        .count_o     (rx_cnt)
    );

    spif_regs #(.DEPTH(DEPTH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_mode_i   (wr_any && bus_addr_i == ADR_MODE),
        .wr_evt_i    (wr_any && bus_addr_i == ADR_EVT),
        .wr_mask_i   (wr_any && bus_addr_i == ADR_MASK),
        .wdata_i     (bus_wdata_i),
        .done_i      (done_i),
        .rx_cnt_i    (rx_cnt),
        .tx_cnt_i    (tx_cnt),
        .mode_o      (mode),
        .mode_word_o (mode_word),
        .evt_o       (evt_word),
        .mask_o      (mask_word),
        .irq_o       (irq_o)
    );

    spif_ctl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (mode.en),
        .tx_pending_i (tx_cnt != '0),
        .done_i       (done_i),
        .state_o      (state),
        .busy_o       (busy_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADR_MODE: bus_rdata_o = mode_word;
            ADR_EVT:  bus_rdata_o = evt_word;
            ADR_MASK: bus_rdata_o = mask_word;
            ADR_RXD: begin
                for (int k = 0; k < int'(LANES); k++) begin
                    if (k < nb) bus_rdata_o[8*(nb-1-k) +: 8] = rx_peek[8*k +: 8];
                end
            end
            default: bus_rdata_o = '0;
        endcase
    end

    assign tx_byte_o  = tx_peek[7:0];
    assign tx_avail_o = (tx_cnt != '0);
    assign enable_o   = mode.en;
    assign loop_o     = mode.lp;

    // R12: busy only outside OFF
    p_busy_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> state != ST_OFF);

    // R10: a disabled unit holds both queues empty on the next cycle
    p_flushed_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.en |=> (tx_cnt == '0 && rx_cnt == '0));

endmodule

// File: tb/spif_event_unit_tb.sv
`timescale 1ns/1ps
module spif_event_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        rx_push = 0;
    logic [7:0]  rx_byte = '0;
    logic        done = 0;
    logic        enable, loopb, busy, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit en_m = 0;
    byte unsigned tx_q[$];
    byte unsigned rx_q[$];

    localparam logic [4:0] A_MODE = 5'h00, A_EVT = 5'h04, A_MASK = 5'h08,
                           A_TXD = 5'h0C, A_RXD = 5'h10;

    always #2.5 clk = ~clk;

    spif_event_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_size_i(bus_size), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .tx_pop_i(tx_pop), .tx_byte_o(tx_byte),
        .tx_avail_o(tx_avail), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
        .done_i(done), .enable_o(enable), .loop_o(loopb), .busy_o(busy), .irq_o(irq)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_evt(int rxn, int txn, int rxt, int txt);
        logic [31:0] v = '0;
        int fr = 32 - txn;
        v[29:24] = 6'(rxn);
        v[21:16] = 6'(fr);
        v[15] = (txn == 0);
        v[13] = (rxn > rxt);
        v[12] = (rxn == 32);
        v[11] = (fr > txt);
        v[9]  = (rxn != 0);
        v[8]  = (fr != 0);
        return v;
    endfunction

    task automatic bw(logic [4:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic br(logic [4:0] a, logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = s;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_push_m(logic [1:0] s, logic [31:0] d);
        int n = nbytes(s);
        if (en_m && (32 - tx_q.size()) >= n)
            for (int k = 0; k < n; k++) tx_q.push_back(d[8*(n-1-k) +: 8]);
        bw(A_TXD, s, d);
    endtask

    task automatic tx_pop_m(string req);
        logic [7:0] e;
        e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
        @(negedge clk);
        tx_pop = 1;
        #1 chk(req, {24'h0, tx_byte}, {24'h0, e});
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic rx_push_m(logic [7:0] b);
        if (en_m && rx_q.size() < 32) rx_q.push_back(b);
        @(negedge clk);
        rx_push = 1; rx_byte = b;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic rx_read_m(logic [1:0] s, string req);
        int n = nbytes(s);
        logic [31:0] e = '0, d;
        for (int k = 0; k < n; k++)
            e[8*(n-1-k) +: 8] = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
        br(A_RXD, s, d);
        chk(req, d, e);
    endtask

    task automatic flag_check(string req, int rxt, int txt);
        logic [31:0] d;
        bw(A_EVT, 2'd2, 32'hFFFF_FFFF);
        br(A_EVT, 2'd2, d);
        chk(req, d, en_m ? exp_evt(rx_q.size(), tx_q.size(), rxt, txt) : 32'h0020_0000);
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1;
        @(negedge clk); done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1;
        idle(1);

        // reset state
        br(A_MODE, 2'd2, d);  chk("R8 reset mode", d, 32'h0000_040F);
        br(A_EVT, 2'd2, d);   chk("R2 reset status", d, 32'h0020_0000);
        chk("R5 reset irq", {31'h0, irq}, 0);
        chk("R10 reset enable", {31'h0, enable}, 0);
        chk("R12 reset busy", {31'h0, busy}, 0);

        // enable
        bw(A_MODE, 2'd2, 32'h8000_040F); en_m = 1;
        chk("R8 enable bit", {31'h0, enable}, 1);
        flag_check("R3 empty flags", 15, 4);
        chk("R3 empty value", exp_evt(0, 0, 15, 4), 32'h0020_8900);

        // mask and interrupt
        bw(A_MASK, 2'd2, 32'h0000_4000);
        br(A_MASK, 2'd2, d); chk("R5 mask readback", d, 32'h0000_4000);
        idle(1); chk("R5 irq masked", {31'h0, irq}, 0);
        pulse_done(); idle(1);
        chk("R5 irq on done", {31'h0, irq}, 1);
        br(A_EVT, 2'd2, d); chk("R3 done flag", {31'h0, d[14]}, 1);
        bw(A_EVT, 2'd2, 32'h0000_4000); idle(1);
        br(A_EVT, 2'd2, d); chk("R4 done cleared", {31'h0, d[14]}, 0);
        chk("R5 irq after clear", {31'h0, irq}, 0);
        bw(A_MASK, 2'd2, 32'h0000_8000); idle(1);
        chk("R5 irq tx empty", {31'h0, irq}, 1);
        bw(A_MASK, 2'd2, 32'h0); idle(1);
        chk("R5 irq unmasked off", {31'h0, irq}, 0);

        // controller states
        tx_push_m(2'd0, 32'h0000_005A); idle(2);
        chk("R12 start to RUN", {31'h0, busy}, 1);
        tx_pop_m("R12 pop byte"); idle(1);
        chk("R12 holds RUN", {31'h0, busy}, 1);
        pulse_done(); idle(1);
        chk("R12 finish to IDLE", {31'h0, busy}, 0);

        // transmit fill, overflow, byte order
        for (int i = 0; i < 8; i++) tx_push_m(2'd2, 32'h0102_0304 + 32'h1010_1010 * i);
        tx_push_m(2'd0, 32'h0000_00AA);
        tx_push_m(2'd1, 32'h0000_BBCC);
        flag_check("R1 tx full status", 15, 4);
        br(A_EVT, 2'd2, d); chk("R11 tx free zero", {26'h0, d[21:16]}, 0);
        for (int i = 0; i < 32; i++) tx_pop_m("R6 tx byte order");
        tx_pop_m("R11 tx empty pop");
        tx_push_m(2'd1, 32'h0000_A1B2);
        tx_push_m(2'd0, 32'h0000_00C3);
        for (int i = 0; i < 3; i++) tx_pop_m("R6 mixed widths");
        pulse_done();

        // receive partial and empty reads
        rx_push_m(8'h11); rx_push_m(8'h22);
        rx_read_m(2'd2, "R7 partial word");
        rx_read_m(2'd0, "R7 empty read");
        rx_push_m(8'h33); rx_push_m(8'h44); rx_push_m(8'h55);
        rx_read_m(2'd1, "R7 halfword");
        rx_read_m(2'd0, "R7 byte");

        // receive full
        for (int i = 0; i < 33; i++) rx_push_m(8'(8'h80 + i));
        flag_check("R11 rx full", 15, 4);
        for (int i = 0; i < 9; i++) rx_read_m(2'd2, "R11 rx drain");

        // thresholds
        bw(A_MODE, 2'd2, 32'h8000_0403);
        for (int i = 0; i < 3; i++) rx_push_m(8'(i));
        flag_check("R9 rx at threshold", 3, 4);
        rx_push_m(8'h03);
        flag_check("R9 rx above threshold", 3, 4);
        bw(A_MODE, 2'd2, 32'h8000_1F03);
        flag_check("R9 tx free above", 3, 31);
        tx_push_m(2'd0, 32'h0000_0077);
        flag_check("R9 tx free at threshold", 3, 31);
        tx_pop_m("R9 drain");
        rx_read_m(2'd2, "R9 drain");
        pulse_done();

        // mode fields
        bw(A_MODE, 2'd2, 32'hC000_0A07);
        br(A_MODE, 2'd2, d); chk("R8 mode readback", d, 32'hC000_0A07);
        chk("R8 loop bit", {31'h0, loopb}, 1);
        bw(A_MODE, 2'd2, 32'h8000_040F);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 4;
            case (op)
                0: tx_push_m(2'($urandom % 3), $urandom);
                1: tx_pop_m("R6 random tx");
                2: rx_push_m(8'($urandom));
                default: rx_read_m(2'($urandom % 3), "R7 random rx");
            endcase
            if (it % 40 == 39) flag_check("R2 R3 random status", 15, 4);
        end

        // disable
        rx_push_m(8'h9C); tx_push_m(2'd0, 32'h0000_0011);
        bw(A_MODE, 2'd2, 32'h0000_040F); en_m = 0;
        tx_q.delete(); rx_q.delete();
        idle(1);
        chk("R10 enable off", {31'h0, enable}, 0);
        chk("R10 busy off", {31'h0, busy}, 0);
        flag_check("R10 flushed", 15, 4);
        pulse_done();
        rx_push_m(8'h12);
        tx_push_m(2'd2, 32'hDEAD_BEEF);
        idle(1);
        br(A_EVT, 2'd2, d); chk("R10 ignored while off", d, 32'h0020_0000);
        chk("R10 tx idle", {31'h0, tx_avail}, 0);

        finish_run();
    end

endmodule